// File: doc/BRIEF.md
# Single-Wire Pulse-Count Output Controller

This block turns one slow control wire into seven output-enable bits. A host sends bursts of rising edges on the wire, with quiet stretches between bursts. After two synchronising flops, the block counts the edges of each burst in the system clock domain. A burst is over once the wire has shown no new edge for a programmable number of clock cycles. At that point the count goes to a decoder and the counter is cleared.

Commands come as pairs of bursts. The first burst of a pair is the address burst and picks one of two target maps. The second burst is the data burst, and its length picks a single channel within that map. Each accepted command switches on one more channel and leaves the others as they were. The host can therefore bring the outputs up in any order it likes. There is also a shortcut: after reset, once the wire has been quiet for a full timeout, the first edge that arrives switches on a default group of five channels at once.

Top module: `swire_out_ctl`

## Requirements
- R1: Rising edges on `ctl_in` are counted only after a two-flop synchroniser. Each detected edge adds one to the count of the current burst.
- R2: A burst ends when `tlat_cycles` clock cycles have passed with no detected edge. Every detected edge restarts this idle timer, so edges spaced closer than the timeout belong to the same burst. When a burst ends, the count is cleared.
- R3: An address burst of 34 edges followed by a data burst of 32 edges sets `out_en[0]`.
- R4: After an address burst of 33 edges, a data burst sets one bit according to its length: 32 sets `out_en[1]`, 16 sets `out_en[2]`, 8 sets `out_en[3]`, 4 sets `out_en[4]`, 2 sets `out_en[5]` and 1 sets `out_en[6]`.
- R5: A command only ever sets bits. Channels that are already on stay on, and no bit is cleared except by reset.
- R6: The default group, `out_en[6:2]`, is set by the first detected edge after reset, but only if the idle timer had already reached `tlat_cycles` when that edge arrived. This happens at most once per reset.
- R7: An address burst with any count other than 33 or 34 leaves `out_en` unchanged. The decoder then stays waiting for an address burst.
- R8: A data burst whose count matches no channel of the selected map leaves `out_en` unchanged. The next burst is then treated as an address burst.
- R9: The edge count saturates at 63. A burst of 97 edges therefore never decodes as 33.
- R10: While `rst_n` is low, `out_en` is all zero. Reset also clears the burst count and the address/data phase, and it restarts the idle timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_in | input | 1 | Asynchronous single-wire control input |
| tlat_cycles | input | TMR_W | Idle timeout, in clock cycles, that ends a burst |
| out_en | output | 7 | Channel enables; bit 0 is the first channel |

## Verification
The sequence that starts right after reset checks three things. It sends every valid address/data pair, which checks the channel map. It checks that enables accumulate. Because the first edge comes before any timeout, it also shows that the default group is not applied in that case.
Invalid address lengths and unmatched data lengths are each followed by a valid pair. Whether that pair lands shows which phase the decoder returned to.
A 97-edge burst separates a saturating counter from one that wraps to 33.
Two further cases check how bursts are split. One burst has a pause shorter than the timeout inside it and must still count as a single burst. In the other case, two bursts are separated by a pause longer than the timeout and must be counted apart.
A second reset followed by a long quiet stretch checks the default group and checks that it fires only once.

// File: rtl/swire_out_ctl.sv
module swire_out_ctl #(
  parameter int CNT_W = 6,
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_in,
  input  logic [TMR_W-1:0] tlat_cycles,
  output logic [6:0]       out_en
);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ADDR_ONE = CNT_W'(34);
  localparam logic [CNT_W-1:0] ADDR_MAP = CNT_W'(33);
  localparam logic [6:0]       DEF_GRP  = 7'b1111100;

  logic [2:0]       sync_q;
  logic [CNT_W-1:0] cnt;
  logic [TMR_W-1:0] tmr;
  logic             active, fresh, data_ph, sel_one;
  logic [6:0]       data_mask;

  wire edge_det  = sync_q[1] & ~sync_q[2];
  wire tmo       = (tmr >= tlat_cycles);
  wire burst_end = active & ~edge_det & tmo;

  always_comb begin
    data_mask = '0;
    if (sel_one) begin
      if (cnt == CNT_W'(32)) data_mask[0] = 1'b1;
    end else begin
      case (cnt)
        CNT_W'(32): data_mask[1] = 1'b1;
        CNT_W'(16): data_mask[2] = 1'b1;
        CNT_W'(8):  data_mask[3] = 1'b1;
        CNT_W'(4):  data_mask[4] = 1'b1;
        CNT_W'(2):  data_mask[5] = 1'b1;
        CNT_W'(1):  data_mask[6] = 1'b1;
        default:    data_mask    = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q  <= '0;
      cnt     <= '0;
      tmr     <= '0;
      active  <= 1'b0;
      fresh   <= 1'b1;
      data_ph <= 1'b0;
      sel_one <= 1'b0;
      out_en  <= '0;
    end else begin
      sync_q <= {sync_q[1:0], ctl_in};
      if (edge_det) begin
        cnt    <= (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
        tmr    <= '0;
        active <= 1'b1;
        fresh  <= 1'b0;
        if (fresh && tmo) out_en <= out_en | DEF_GRP;
      end else begin
        if (!tmo) tmr <= tmr + 1'b1;
        if (burst_end) begin
          cnt    <= '0;
          active <= 1'b0;
          if (!data_ph) begin
            if (cnt == ADDR_ONE) begin
              data_ph <= 1'b1;
              sel_one <= 1'b1;
            end else if (cnt == ADDR_MAP) begin
              data_ph <= 1'b1;
              sel_one <= 1'b0;
            end
          end else begin
            data_ph <= 1'b0;
            out_en  <= out_en | data_mask;
          end
        end
      end
    end
  end
endmodule

module swire_out_ctl_chk #(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             edge_det,
  input logic [CNT_W-1:0] cnt,
  input logic [6:0]       out_en
);
  // R5
  enables_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(out_en) & ~out_en) == 7'b0)));

  // R5
  one_or_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($countones(out_en & ~$past(out_en)) <= 1) ||
     ((out_en & ~$past(out_en)) == 7'b1111100)));

  // R9
  cnt_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_det && (cnt == {CNT_W{1'b1}})) |=> (cnt == {CNT_W{1'b1}}));

  // R1
  edge_counts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_det |=> (cnt != '0));

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (out_en == 7'b0));
endmodule

bind swire_out_ctl swire_out_ctl_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .edge_det(edge_det), .cnt(cnt), .out_en(out_en));

// File: tb/swire_out_ctl_tb.sv
module swire_out_ctl_tb_top;
  localparam int TLAT = 20;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_in = 1'b0;
  logic [15:0] tlat_cycles = 16'(TLAT);
  logic [6:0]  out_en;
  int vectors = 0, miscompares = 0;
  string cur_req = "R10";

  always #4 clk = ~clk;

  swire_out_ctl dut_i (.clk(clk), .rst_n(rst_n), .ctl_in(ctl_in),
                       .tlat_cycles(tlat_cycles), .out_en(out_en));

  // behavioural reference
  int m1, m2, m3, mcnt, mtmr;
  bit mact, mfresh, mdata, msel1;
  bit [6:0] men;
  always @(posedge clk) begin
    if (!rst_n) begin
      m1 = 0; m2 = 0; m3 = 0; mcnt = 0; mtmr = 0;
      mact = 0; mfresh = 1; mdata = 0; msel1 = 0; men = '0;
    end else begin
      if (m2 == 1 && m3 == 0) begin
        if (mfresh && mtmr >= TLAT) men = men | 7'b1111100;
        mfresh = 0;
        if (mcnt < 63) mcnt++;
        mtmr = 0;
        mact = 1;
      end else begin
        if (mact && mtmr >= TLAT) begin
          if (!mdata) begin
            if (mcnt == 34) begin mdata = 1; msel1 = 1; end
            else if (mcnt == 33) begin mdata = 1; msel1 = 0; end
          end else begin
            mdata = 0;
            if (msel1) begin
              if (mcnt == 32) men[0] = 1;
            end else begin
              case (mcnt)
                32: men[1] = 1;
                16: men[2] = 1;
                8:  men[3] = 1;
                4:  men[4] = 1;
                2:  men[5] = 1;
                1:  men[6] = 1;
                default: ;
              endcase
            end
          end
          mcnt = 0;
          mact = 0;
        end
        if (mtmr < TLAT) mtmr++;
      end
      m3 = m2; m2 = m1; m1 = int'(ctl_in);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      vectors++;
      if (out_en !== men) begin
        miscompares++;
        $display("FAIL %s model: out_en=%b expected %b", cur_req, out_en, men);
      end
    end
  end

  task automatic chk(input string tag, input logic [6:0] exp);
    vectors++;
    if (out_en !== exp) begin
      miscompares++;
      $display("FAIL %s: out_en=%b expected %b", tag, out_en, exp);
    end
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) ctl_in = 1'b1;
      @(negedge clk);
      @(negedge clk) ctl_in = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic gap(input int c);
    repeat (c) @(negedge clk);
  endtask

  task automatic cmd(input int a, input int d);
    pulses(a); gap(TLAT + 10);
    pulses(d); gap(TLAT + 10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10", 7'b0);
    rst_n = 1'b1;
    // R1 R3: first edge well before timeout, no default group
    cur_req = "R3";
    cmd(34, 32); chk("R3", 7'b0000001);
    cur_req = "R4";
    cmd(33, 32); chk("R4", 7'b0000011);
    cur_req = "R5";
    cmd(33, 16); chk("R5", 7'b0000111);
    cur_req = "R7";
    pulses(10); gap(TLAT + 10); chk("R7", 7'b0000111);
    cmd(33, 4); chk("R7", 7'b0010111);
    cur_req = "R8";
    cmd(33, 5); chk("R8", 7'b0010111);
    cmd(33, 8); chk("R8", 7'b0011111);
    cur_req = "R9";
    cmd(97, 2); chk("R9", 7'b0011111);
    cur_req = "R2";
    pulses(20); gap(TLAT - 6); pulses(13); gap(TLAT + 10);
    pulses(1); gap(TLAT + 10); chk("R2", 7'b1011111);
    pulses(16); gap(TLAT + 10); pulses(17); gap(TLAT + 10);
    chk("R2", 7'b1011111);
    cmd(33, 2); chk("R2", 7'b1111111);
    cur_req = "R10";
    @(negedge clk) rst_n = 1'b0;
    gap(2); chk("R10", 7'b0);
    rst_n = 1'b1;
    gap(TLAT + 20);
    chk("R10", 7'b0);
    cur_req = "R6";
    pulses(1); gap(TLAT + 10); chk("R6", 7'b1111100);
    pulses(1); gap(TLAT + 10); chk("R6", 7'b1111100);
    cur_req = "R3";
    cmd(34, 32); chk("R3", 7'b1111101);
    gap(5);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run hung, actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule